// File: doc/BRIEF.md
# Three-Phase Power Combiner

This block merges three signed per-phase active-power samples into one combined power value for a three-phase meter. The downstream energy-to-pulse stage consumes that value. Two static strap inputs choose how the phases merge. One selects the wiring: four-wire star or three-wire delta. The other is a summation select. Together they pick algebraic addition, where each phase adds with its sign, or absolute addition, where each phase adds by magnitude. In three-wire operation only two measuring elements are used: phase A and phase C. Phase B never enters the sum.

Each phase is qualified on every sample using its voltage and current magnitudes. A phase whose voltage is below a wiring-dependent fraction of nominal is flagged as lost. A phase whose current is below one thousandth of rated current is flagged as no-load. Either condition removes that phase from the sum and from the reverse-power evaluation. The block also produces two flags. The reverse flag is set when any contributing phase carries negative power. The negative-combined flag gives the sign of the sum in algebraic mode. All results are registered, change only on a sample strobe, and appear one clock after it.

Top module: `three_phase_combiner`

## Requirements
- R1: Algebraic addition is used when `wire4_sel` equals `sum_sel`: four-wire with summation high, or three-wire with summation low. Absolute addition is used in the other two combinations.
- R2: In absolute mode each contributing phase adds its magnitude, so `sum_out` is never negative. This includes a phase sample of the most negative code.
- R3: With `wire4_sel` low (three-wire), phase B (index 1) never contributes to `sum_out` or to `rev_flag`. Phases A (index 0) and C (index 2) do.
- R4: `rev_flag` is high exactly when at least one contributing phase has a negative power sample. A phase contributes when its element is enabled, it is not voltage-lost and it is not no-load.
- R5: In algebraic mode `neg_flag` equals the sign of the combined sum. In absolute mode it is low.
- R6: Bit i of `vloss_flag` (0=A, 1=B, 2=C) is set when `phase_vmag[i]` is strictly below NOM_V*15/100 in four-wire mode, or strictly below NOM_V*60/100 in three-wire mode. A lost phase adds zero and is left out of `rev_flag`.
- R7: Bit i of `noload_flag` is set when `phase_imag[i]` is strictly below RATED_I/1000. Such a phase adds zero and is left out of `rev_flag`.
- R8: All outputs update on the clock edge that samples `smp_vld` high. They hold between strobes. `out_vld` is high for exactly the one cycle after each strobe.
- R9: `sum_out` is PWR_W+2 bits wide and holds the exact sum of three full-scale samples of either sign without overflow.
- R10: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wire4_sel | input | 1 | Wiring select: 1 four-wire, 0 three-wire (static) |
| sum_sel | input | 1 | Summation select (static) |
| smp_vld | input | 1 | Sample strobe, one cycle per sample |
| phase_pwr | input | 3 x PWR_W | Signed power per phase, index 0=A, 1=B, 2=C |
| phase_vmag | input | 3 x MAG_W | Unsigned voltage magnitude per phase |
| phase_imag | input | 3 x MAG_W | Unsigned current magnitude per phase |
| sum_out | output | PWR_W+2 | Signed combined power |
| rev_flag | output | 1 | A contributing phase is negative |
| neg_flag | output | 1 | Algebraic sum is negative |
| vloss_flag | output | 3 | Per-phase voltage-loss qualifier |
| noload_flag | output | 3 | Per-phase no-load qualifier |
| out_vld | output | 1 | Outputs refreshed this cycle |

## Verification
Every result register loads only on a strobe, so a wrong value lands in a port on the cycle after the faulty sample. It then stays there until the next strobe, which is why each check samples a single clock after its strobe. Three kinds of error show up differently. A bad mode decode gives a wrong sign or magnitude of `sum_out` in one of the four strap combinations. A qualifier compared against the wrong boundary is caught by vectors one code either side of each threshold. A phase that wrongly stays enabled in three-wire mode shows as phase B's value leaking into `sum_out` or `rev_flag`.

// File: rtl/pcomb_pkg.sv
package pcomb_pkg;

    localparam int NUM_PH = 3;

    typedef enum logic {
        ADD_ABS = 1'b0,
        ADD_ALG = 1'b1
    } add_mode_e;

endpackage

// File: rtl/pcomb_mode_dec.sv
module pcomb_mode_dec
    import pcomb_pkg::*;
#(
    parameter int MAG_W  = 16,
    parameter int THR_4W = 6000,
    parameter int THR_3W = 24000
) (
    input  logic              wire4_sel,
    input  logic              sum_sel,
    output add_mode_e         add_mode,
    output logic [NUM_PH-1:0] elem_en,
    output logic [MAG_W-1:0]  vloss_thr
);

    localparam logic [MAG_W-1:0] THR4 = MAG_W'(THR_4W);
    localparam logic [MAG_W-1:0] THR3 = MAG_W'(THR_3W);

    // crossed mapping: matching straps give signed summation
    always_comb begin
        add_mode = (wire4_sel == sum_sel) ? ADD_ALG : ADD_ABS;
    end

    // two-element method in delta wiring: middle phase is dropped
    always_comb begin
        elem_en    = '1;
        elem_en[1] = wire4_sel;
    end

    always_comb begin
        vloss_thr = wire4_sel ? THR4 : THR3;
    end

endmodule

// File: rtl/pcomb_phase_qual.sv
module pcomb_phase_qual
    import pcomb_pkg::*;
#(
    parameter int PWR_W     = 24,
    parameter int MAG_W     = 16,
    parameter int CREEP_THR = 20
) (
    input  logic [PWR_W-1:0] pwr,
    input  logic [MAG_W-1:0] vmag,
    input  logic [MAG_W-1:0] imag,
    input  logic             elem_en,
    input  logic [MAG_W-1:0] vloss_thr,
    input  add_mode_e        add_mode,
    output logic             vloss,
    output logic             noload,
    output logic [PWR_W:0]   contrib,
    output logic             neg_contrib
);

    localparam int EXT_W = PWR_W + 1;
    localparam logic [MAG_W-1:0] CREEP = MAG_W'(CREEP_THR);

    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] mag;
    logic                    active;

    always_comb begin
        vloss  = vmag < vloss_thr;
        noload = imag < CREEP;
        active = elem_en && !vloss && !noload;
    end

    // one guard bit so the magnitude of the most negative code fits
    always_comb begin
        ext = EXT_W'($signed(pwr));
        mag = ext[EXT_W-1] ? -ext : ext;
    end

    always_comb begin
        if (!active) begin
            contrib = '0;
        end else if (add_mode == ADD_ALG) begin
            contrib = ext;
        end else begin
            contrib = mag;
        end
        neg_contrib = active && pwr[PWR_W-1];
    end

endmodule

// File: rtl/pcomb_adder.sv
module pcomb_adder #(
    parameter int IN_W  = 25,
    parameter int N_IN  = 3,
    parameter int OUT_W = 26
) (
    input  logic [N_IN-1:0][IN_W-1:0] terms,
    output logic [OUT_W-1:0]          total
);

    logic signed [OUT_W-1:0] partial [N_IN+1];

    assign partial[0] = '0;

    for (genvar g = 0; g < N_IN; g++) begin : g_acc
        logic signed [OUT_W-1:0] term_ext;
        assign term_ext       = OUT_W'($signed(terms[g]));
        assign partial[g + 1] = partial[g] + term_ext;
    end

    assign total = partial[N_IN];

endmodule

// File: rtl/three_phase_combiner.sv
module three_phase_combiner
    import pcomb_pkg::*;
#(
    parameter int PWR_W   = 24,
    parameter int MAG_W   = 16,
    parameter int NOM_V   = 40000,
    parameter int RATED_I = 20000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wire4_sel,
    input  logic                            sum_sel,
    input  logic                            smp_vld,
    input  logic [NUM_PH-1:0][PWR_W-1:0]    phase_pwr,
    input  logic [NUM_PH-1:0][MAG_W-1:0]    phase_vmag,
    input  logic [NUM_PH-1:0][MAG_W-1:0]    phase_imag,
    output logic signed [PWR_W+1:0]         sum_out,
    output logic                            rev_flag,
    output logic                            neg_flag,
    output logic [NUM_PH-1:0]               vloss_flag,
    output logic [NUM_PH-1:0]               noload_flag,
    output logic                            out_vld
);

    localparam int CTR_W     = PWR_W + 1;
    localparam int SUM_W     = PWR_W + 2;
    localparam int THR_4W    = NOM_V * 15 / 100;
    localparam int THR_3W    = NOM_V * 60 / 100;
    localparam int CREEP_THR = RATED_I / 1000;

    typedef struct packed {
        logic signed [SUM_W-1:0] sum;
        logic                    rev;
        logic                    neg;
        logic [NUM_PH-1:0]       vloss;
        logic [NUM_PH-1:0]       noload;
        logic                    vld;
    } state_t;

    add_mode_e                     add_mode;
    logic [NUM_PH-1:0]             elem_en;
    logic [MAG_W-1:0]              vloss_thr;
    logic [NUM_PH-1:0]             vloss_w;
    logic [NUM_PH-1:0]             noload_w;
    logic [NUM_PH-1:0]             neg_w;
    logic [NUM_PH-1:0][CTR_W-1:0]  contrib_w;
    logic [SUM_W-1:0]              total_w;

    state_t state_d;
    state_t state_q;

    pcomb_mode_dec #(
        .MAG_W  (MAG_W),
        .THR_4W (THR_4W),
        .THR_3W (THR_3W)
    ) i_mode_dec (
        .wire4_sel (wire4_sel),
        .sum_sel   (sum_sel),
        .add_mode  (add_mode),
        .elem_en   (elem_en),
        .vloss_thr (vloss_thr)
    );

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        pcomb_phase_qual #(
            .PWR_W     (PWR_W),
            .MAG_W     (MAG_W),
            .CREEP_THR (CREEP_THR)
        ) i_qual (
            .pwr         (phase_pwr[p]),
            .vmag        (phase_vmag[p]),
            .imag        (phase_imag[p]),
            .elem_en     (elem_en[p]),
            .vloss_thr   (vloss_thr),
            .add_mode    (add_mode),
            .vloss       (vloss_w[p]),
            .noload      (noload_w[p]),
            .contrib     (contrib_w[p]),
            .neg_contrib (neg_w[p])
        );
    end

    pcomb_adder #(
        .IN_W  (CTR_W),
        .N_IN  (NUM_PH),
        .OUT_W (SUM_W)
    ) i_adder (
        .terms (contrib_w),
        .total (total_w)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = smp_vld;
        if (smp_vld) begin
            state_d.sum    = $signed(total_w);
            state_d.rev    = |neg_w;
            state_d.neg    = (add_mode == ADD_ALG) && total_w[SUM_W-1];
            state_d.vloss  = vloss_w;
            state_d.noload = noload_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sum_out     = state_q.sum;
    assign rev_flag    = state_q.rev;
    assign neg_flag    = state_q.neg;
    assign vloss_flag  = state_q.vloss;
    assign noload_flag = state_q.noload;
    assign out_vld     = state_q.vld;

endmodule

// File: rtl/pcomb_checker.sv
module pcomb_checker
    import pcomb_pkg::*;
#(
    parameter int PWR_W     = 24,
    parameter int MAG_W     = 16,
    parameter int CREEP_THR = 20
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wire4_sel,
    input logic                         sum_sel,
    input logic                         smp_vld,
    input logic [NUM_PH-1:0][MAG_W-1:0] phase_imag,
    input logic signed [PWR_W+1:0]      sum_out,
    input logic                         rev_flag,
    input logic                         neg_flag,
    input logic                         out_vld
);

    localparam int SUM_W = PWR_W + 2;
    localparam logic [MAG_W-1:0] CREEP = MAG_W'(CREEP_THR);

    logic [NUM_PH-1:0] idle_ph;
    logic              abs_sel;

    for (genvar p = 0; p < NUM_PH; p++) begin : g_idle
        assign idle_ph[p] = phase_imag[p] < CREEP;
    end

    assign abs_sel = wire4_sel != sum_sel;

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) smp_vld |=> out_vld); // R8
    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !smp_vld |=> !out_vld); // R8
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n) !smp_vld |=> ($stable(sum_out) && $stable(rev_flag) && $stable(neg_flag))); // R8
    AST_ABS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n) (smp_vld && abs_sel) |=> !sum_out[SUM_W-1]); // R2
    AST_ABS_NEG_LOW: assert property (@(posedge clk) disable iff (!rst_n) (smp_vld && abs_sel) |=> !neg_flag); // R5
    AST_NEG_IS_SIGN: assert property (@(posedge clk) disable iff (!rst_n) neg_flag |-> sum_out[SUM_W-1]); // R5
    AST_NOLOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (smp_vld && (&idle_ph)) |=> (sum_out == '0 && !rev_flag)); // R7

endmodule

bind three_phase_combiner pcomb_checker #(
    .PWR_W     (PWR_W),
    .MAG_W     (MAG_W),
    .CREEP_THR (RATED_I / 1000)
) i_pcomb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wire4_sel  (wire4_sel),
    .sum_sel    (sum_sel),
    .smp_vld    (smp_vld),
    .phase_imag (phase_imag),
    .sum_out    (sum_out),
    .rev_flag   (rev_flag),
    .neg_flag   (neg_flag),
    .out_vld    (out_vld)
);

// File: tb/test_three_phase_combiner.sv
`timescale 1ns/1ps
module test_three_phase_combiner;

    localparam int PW = 24;
    localparam int MW = 16;
    localparam int SW = PW + 2;
    localparam logic [MW-1:0] VN = 16'd40000;
    localparam logic [MW-1:0] IN = 16'd1000;

    typedef struct packed {
        logic                 w4;
        logic                 sm;
        logic signed [PW-1:0] pa;
        logic signed [PW-1:0] pb;
        logic signed [PW-1:0] pc;
        logic [MW-1:0]        va;
        logic [MW-1:0]        vb;
        logic [MW-1:0]        vc;
        logic [MW-1:0]        ia;
        logic [MW-1:0]        ib;
        logic [MW-1:0]        ic;
        logic signed [SW-1:0] esum;
        logic                 erev;
        logic                 eneg;
        logic [2:0]           evl;
        logic [2:0]           ecr;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1,1,  100,  200,  300, VN,VN,VN, IN,IN,IN,  600,0,0,3'b000,3'b000}, // R1 alg 4w
        '{1,1,  100, -500,  200, VN,VN,VN, IN,IN,IN, -200,1,1,3'b000,3'b000}, // R1 R4 R5
        '{1,0,  100, -500,  200, VN,VN,VN, IN,IN,IN,  800,1,0,3'b000,3'b000}, // R2 abs 4w
        '{0,0,  100, -500,  200, VN,VN,VN, IN,IN,IN,  300,0,0,3'b000,3'b000}, // R3 alg 3w
        '{0,1, -100,  999, -200, VN,VN,VN, IN,IN,IN,  300,1,0,3'b000,3'b000}, // R2 R3 abs 3w
        '{0,0, -400,   50,  100, VN,VN,VN, IN,IN,IN, -300,1,1,3'b000,3'b000}, // R3 R5
        '{1,1, 1000,   -7,   20, 5999,VN,VN, IN,IN,IN, 13,1,0,3'b001,3'b000}, // R6 below 15%
        '{1,1, 1000,   -7,   20, 6000,VN,VN, IN,IN,IN, 1013,1,0,3'b000,3'b000}, // R6 at 15%
        '{0,0,  -50,    9,  -70, 24000,VN,23999, IN,IN,IN, -50,1,1,3'b100,3'b000}, // R6 3w
        '{1,1,   10, -300,   20, VN,VN,VN, IN,19,IN,  30,0,0,3'b000,3'b010}, // R7 below
        '{1,1,   10, -300,   20, VN,VN,VN, IN,20,IN, -270,1,1,3'b000,3'b000}, // R7 at limit
        '{1,1, 8388607, 8388607, 8388607, VN,VN,VN, IN,IN,IN, 25165821,0,0,3'b000,3'b000}, // R9
        '{1,1, -8388608, -8388608, -8388608, VN,VN,VN, IN,IN,IN, -25165824,1,1,3'b000,3'b000}, // R9
        '{1,0, -8388608, -8388608, -8388608, VN,VN,VN, IN,IN,IN, 25165824,1,0,3'b000,3'b000}, // R2 R9
        '{0,0,    5,    7,    6, VN,100,VN, IN,IN,IN,  11,0,0,3'b010,3'b000}, // R3 R6
        '{1,1,    1,    1,    1, VN,10000,VN, IN,IN,IN, 3,0,0,3'b000,3'b000}, // R6 4w pass
        '{0,0,    1,    1,    1, VN,10000,VN, IN,IN,IN, 2,0,0,3'b010,3'b000}, // R6 3w lost
        '{1,0, -900,   40,  -60, VN,VN,100, 5,IN,IN,  40,0,0,3'b100,3'b001}  // R4 R6 R7
    };

    logic                       clk;
    logic                       rst_n;
    logic                       wire4_sel;
    logic                       sum_sel;
    logic                       smp_vld;
    logic [2:0][PW-1:0]         phase_pwr;
    logic [2:0][MW-1:0]         phase_vmag;
    logic [2:0][MW-1:0]         phase_imag;
    logic signed [SW-1:0]       sum_out;
    logic                       rev_flag;
    logic                       neg_flag;
    logic [2:0]                 vloss_flag;
    logic [2:0]                 noload_flag;
    logic                       out_vld;

    int n_chk  = 0;
    int n_fail = 0;

    three_phase_combiner #(
        .PWR_W   (PW),
        .MAG_W   (MW),
        .NOM_V   (40000),
        .RATED_I (20000)
    ) i_three_phase_combiner (
        .clk         (clk),
        .rst_n       (rst_n),
        .wire4_sel   (wire4_sel),
        .sum_sel     (sum_sel),
        .smp_vld     (smp_vld),
        .phase_pwr   (phase_pwr),
        .phase_vmag  (phase_vmag),
        .phase_imag  (phase_imag),
        .sum_out     (sum_out),
        .rev_flag    (rev_flag),
        .neg_flag    (neg_flag),
        .vloss_flag  (vloss_flag),
        .noload_flag (noload_flag),
        .out_vld     (out_vld)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic load(input vec_t v);
        wire4_sel  = v.w4;
        sum_sel    = v.sm;
        phase_pwr  = {v.pc, v.pb, v.pa};
        phase_vmag = {v.vc, v.vb, v.va};
        phase_imag = {v.ic, v.ib, v.ia};
    endtask

    // drive at falling edge, strobe for one cycle, sample at the following falling edge
    task automatic apply(input vec_t v, input int idx);
        @(negedge clk);
        load(v);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        chk($sformatf("R1/R2 sum vec%0d", idx), longint'(sum_out), longint'(v.esum));
        chk($sformatf("R4 rev vec%0d", idx), longint'(rev_flag), longint'(v.erev));
        chk($sformatf("R5 neg vec%0d", idx), longint'(neg_flag), longint'(v.eneg));
        chk($sformatf("R6 vloss vec%0d", idx), longint'(vloss_flag), longint'(v.evl));
        chk($sformatf("R7 noload vec%0d", idx), longint'(noload_flag), longint'(v.ecr));
        chk($sformatf("R8 out_vld vec%0d", idx), longint'(out_vld), 1);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        rst_n      = 1'b0;
        smp_vld    = 1'b0;
        wire4_sel  = 1'b1;
        sum_sel    = 1'b1;
        phase_pwr  = '0;
        phase_vmag = '0;
        phase_imag = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 sum", longint'(sum_out), 0);
        chk("R10 flags", longint'({rev_flag, neg_flag, vloss_flag, noload_flag, out_vld}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle after reset", longint'(out_vld), 0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i], i);
        end

        // R8: strobe pulse lasts one cycle, outputs hold while inputs change
        @(negedge clk);
        chk("R8 out_vld drop", longint'(out_vld), 0);
        load(VEC[1]);
        repeat (3) @(negedge clk);
        chk("R8 hold sum", longint'(sum_out), 40);
        chk("R8 hold noload", longint'(noload_flag), 1);
        chk("R8 hold vloss", longint'(vloss_flag), 4);

        // R3: large B power in three-wire mode does not reach the sum or the reverse flag
        begin
            vec_t v;
            v = VEC[3];
            v.pb = -24'sd8000000;
            apply(v, 100);
        end

        // R10: reset during operation clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid-run sum", longint'(sum_out), 0);
        chk("R10 mid-run flags", longint'({rev_flag, neg_flag, vloss_flag, noload_flag}), 0);
        rst_n = 1'b1;
        apply(VEC[0], 200);

        finish_run();
    end

endmodule